// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the front end of a serial-bus slave. It oversamples the clock and data lines with a fast system clock and finds the start, repeated start and stop conditions. It shifts in each byte most significant bit first. From the first byte after a start it decides whether this device is being addressed, and it pulls SDA low in the acknowledge slot when it accepts a byte. The own address is 7 bits or 10 bits wide, chosen by a mode input.

In 10-bit mode the match takes two steps. The first byte carries a fixed prefix, the two upper address bits and the direction bit. The second byte carries the low eight address bits. The block keeps a one-bit record of a completed 10-bit write match. A later repeated start with a matching prefix byte and the read bit set therefore selects the device for reading, and no second address byte is needed.

The general-call address can be enabled. When it is, the command byte that follows produces one-cycle strobes that the surrounding logic acts on. Once a device is selected for writing, the block acknowledges every data byte. Moving data in the read direction, stretching the clock and holding registers belong to other blocks.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset `sdaPullEn`, `selected`, `readMode`, `gcLatch`, `gcReset` and `gcHwCall` are all 0.
- R2: In 7-bit mode (`tenBitMode`=0), a first byte whose upper 7 bits equal `ownAddr[6:0]` and whose bit 0 is 0 is acknowledged. It sets `selected`=1 and `readMode`=0, and every later data byte is acknowledged until the next start or stop.
- R3: A first byte that does not match is not acknowledged. Data bytes that follow are also not acknowledged, and `selected` stays 0 until the next start.
- R4: A matching 7-bit first byte with bit 0 set to 1 is acknowledged and sets `readMode`=1. `readMode` is 1 only while `selected` is 1.
- R5: A stop condition (SDA rising while SCL is high) clears `selected` and `readMode`, and it also clears the record of any 10-bit match.
- R6: A start or repeated start (SDA falling while SCL is high) releases SDA and starts a new address phase. After a repeated start, an address that differs from the own address clears `selected`, while a matching address keeps the device selected with the new direction.
- R7: In 10-bit mode, a first byte of 11110, then `ownAddr[9:8]`, then write bit 0 is acknowledged and leaves `selected`=0. If the next byte equals `ownAddr[7:0]`, that byte is acknowledged and sets `selected`=1 with `readMode`=0.
- R8: In 10-bit mode, a second byte that differs from `ownAddr[7:0]` is not acknowledged and leaves `selected`=0. A prefix byte whose two address bits differ from `ownAddr[9:8]` is not acknowledged.
- R9: After a completed 10-bit write match, a repeated start followed by the matching prefix byte with read bit 1 is acknowledged and sets `selected`=1 and `readMode`=1.
- R10: A 10-bit prefix byte with read bit 1 is not acknowledged unless a 10-bit write match has completed since the last stop.
- R11: The byte 0x00 after a start is acknowledged only when `gcEnable`=1. It never sets `selected`.
- R12: After an accepted general call, command 0x06 is acknowledged and pulses both `gcReset` and `gcLatch`. Command 0x04 is acknowledged and pulses `gcLatch` alone. Command 0x00 and any other even code are not acknowledged and produce no pulse.
- R13: After an accepted general call, an odd command byte is acknowledged, pulses `gcHwCall` and presents the upper 7 bits of that byte on `gcMaster`.
- R14: The block never acknowledges a first byte whose upper 4 bits are 0000 (other than an enabled general call) or whose upper 5 bits are 11111. In 7-bit mode it also never acknowledges a first byte whose upper 4 bits are 1111, even when `ownAddr[6:0]` holds such a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| ownAddr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| tenBitMode | input | 1 | 1 selects 10-bit addressing |
| gcEnable | input | 1 | 1 enables the general-call response |
| sdaPullEn | output | 1 | 1 pulls SDA low (open-drain enable) |
| selected | output | 1 | Device is currently addressed |
| readMode | output | 1 | Selected for a read transfer |
| gcLatch | output | 1 | One-cycle strobe: latch the programmable address bits |
| gcReset | output | 1 | One-cycle strobe: reset requested by general call |
| gcHwCall | output | 1 | One-cycle strobe: hardware general call received |
| gcMaster | output | 7 | Master address carried by the last hardware general call |

## Verification
The bench first targets the 10-bit read shortcut. A design that kept no record of the completed write match would refuse the read after a repeated start, and a design that never cleared the record would accept a read straight after a stop. The bench then sends bytes that a careless comparator would take: reserved codes in both modes, and an own address placed inside the reserved range. A design that matched addresses blindly would pull SDA low on these. The general-call commands are sent one at a time, so that a design which confused 0x04 with 0x06, acknowledged 0x00, or ignored the odd code would show the wrong strobe or acknowledge. Finally, data bytes are sent after a rejected address, and a design that did not stay idle after a mismatch would acknowledge them.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int HW_ADDR_W = BYTE_W - 1;

  // Events the datapath hands to the control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic byteEnd;   // falling SCL after the eighth data bit
  } busEvt_t;

  // Strobes the control hands to the datapath
  typedef struct packed {
    logic ackNow;    // pull SDA for the coming acknowledge slot
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_GC_CMD,
    ST_WRITE,
    ST_READ
  } ctlState_t;

endpackage

// File: rtl/i2c_bus_datapath.sv
module i2c_bus_datapath
  import i2c_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2  // must be 2 or more
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  output busEvt_t           evt,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaPull
);

  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_DONE = CNT_W'(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclNow, sdaNow;
  logic sclRise, sclFall, ackEnd;
  logic [CNT_W-1:0] bitCnt;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // Synchronizers and one stage of history; idle bus reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclNow;
      sdaQ    <= sdaNow;
    end
  end

  assign sclRise      = sclNow & ~sclQ;
  assign sclFall      = ~sclNow & sclQ;
  assign evt.startDet = sclNow & sclQ & sdaQ & ~sdaNow;
  assign evt.stopDet  = sclNow & sclQ & ~sdaQ & sdaNow;
  assign evt.byteEnd  = sclFall && (bitCnt == ACK_SLOT);
  assign ackEnd       = sclFall && (bitCnt == ACK_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (evt.startDet || evt.stopDet) begin
      bitCnt <= '0;
    end else if (sclRise && bitCnt != ACK_DONE) begin
      if (bitCnt < ACK_SLOT) rxByte <= {rxByte[BYTE_W-2:0], sdaNow};
      bitCnt <= bitCnt + 1'b1;
    end else if (ackEnd) begin
      bitCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdaPull <= 1'b0;
    else if (evt.startDet || evt.stopDet || ackEnd) sdaPull <= 1'b0;
    else if (ctl.ackNow) sdaPull <= 1'b1;
  end

  a_r2_pull_in_ack_slot: assert property (@(posedge clk) disable iff (!rstN)
    sdaPull |-> (bitCnt == ACK_SLOT || bitCnt == ACK_DONE));

  a_r6_start_releases: assert property (@(posedge clk) disable iff (!rstN)
    evt.startDet |=> !sdaPull);

endmodule

// File: rtl/i2c_addr_control.sv
module i2c_addr_control
  import i2c_addr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  busEvt_t              evt,
  input  logic [BYTE_W-1:0]    rxByte,
  input  logic [ADDR_W-1:0]    ownAddr,
  input  logic                 tenBitMode,
  input  logic                 gcEnable,
  output dpCtl_t               ctl,
  output logic                 selected,
  output logic                 readMode,
  output logic                 gcLatch,
  output logic                 gcReset,
  output logic                 gcHwCall,
  output logic [HW_ADDR_W-1:0] gcMaster
);

  localparam logic [4:0] TEN_PREFIX = 5'b11110;
  localparam logic [7:0] GC_RESET_LATCH = 8'h06;
  localparam logic [7:0] GC_LATCH_ONLY  = 8'h04;

  ctlState_t state, nState;
  logic tenMatched, nTen, nSel, nRead, ackDecide;
  logic gcL, gcR, gcH;
  logic [HW_ADDR_W-1:0] addrHi;
  logic rwBit, isGc, reserved7, tenPre, sevenHit;

  assign addrHi    = rxByte[BYTE_W-1:1];
  assign rwBit     = rxByte[0];
  assign isGc      = (rxByte == '0);
  assign reserved7 = (addrHi[6:3] == 4'b0000) || (addrHi[6:3] == 4'b1111);
  assign tenPre    = (rxByte[7:3] == TEN_PREFIX) && (rxByte[2:1] == ownAddr[9:8]);
  assign sevenHit  = !tenBitMode && !reserved7 && (addrHi == ownAddr[6:0]);

  always_comb begin
    nState    = state;
    nSel      = selected;
    nRead     = readMode;
    nTen      = tenMatched;
    ackDecide = 1'b0;
    gcL = 1'b0; gcR = 1'b0; gcH = 1'b0;
    if (evt.startDet) begin
      nState = ST_ADDR1;
    end else if (evt.stopDet) begin
      nState = ST_IDLE;
      nSel = 1'b0; nRead = 1'b0; nTen = 1'b0;
    end else if (evt.byteEnd) begin
      unique case (state)
        ST_ADDR1: begin
          nState = ST_IDLE;
          nSel = 1'b0; nRead = 1'b0; nTen = 1'b0;
          if (gcEnable && isGc) begin
            ackDecide = 1'b1;
            nState = ST_GC_CMD;
          end else if (sevenHit) begin
            ackDecide = 1'b1;
            nSel = 1'b1;
            nRead = rwBit;
            nState = rwBit ? ST_READ : ST_WRITE;
          end else if (tenBitMode && tenPre) begin
            if (!rwBit) begin
              ackDecide = 1'b1;
              nState = ST_ADDR2;
            end else if (tenMatched) begin
              ackDecide = 1'b1;
              nSel = 1'b1; nRead = 1'b1; nTen = 1'b1;
              nState = ST_READ;
            end
          end
        end
        ST_ADDR2: begin
          nState = ST_IDLE;
          if (rxByte == ownAddr[7:0]) begin
            ackDecide = 1'b1;
            nSel = 1'b1; nTen = 1'b1;
            nState = ST_WRITE;
          end
        end
        ST_GC_CMD: begin
          nState = ST_IDLE;
          if (rwBit) begin
            ackDecide = 1'b1; gcH = 1'b1;
          end else if (rxByte == GC_RESET_LATCH) begin
            ackDecide = 1'b1; gcL = 1'b1; gcR = 1'b1;
          end else if (rxByte == GC_LATCH_ONLY) begin
            ackDecide = 1'b1; gcL = 1'b1;
          end
        end
        ST_WRITE: ackDecide = 1'b1;
        default: ;
      endcase
    end
  end

  assign ctl.ackNow = ackDecide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      selected   <= 1'b0;
      readMode   <= 1'b0;
      tenMatched <= 1'b0;
      gcLatch    <= 1'b0;
      gcReset    <= 1'b0;
      gcHwCall   <= 1'b0;
      gcMaster   <= '0;
    end else begin
      state      <= nState;
      selected   <= nSel;
      readMode   <= nRead;
      tenMatched <= nTen;
      gcLatch    <= gcL;
      gcReset    <= gcR;
      gcHwCall   <= gcH;
      if (gcH) gcMaster <= addrHi;
    end
  end

  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopDet |=> (!selected && !readMode));

  a_r4_read_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    readMode |-> selected);

  a_r12_reset_implies_latch: assert property (@(posedge clk) disable iff (!rstN)
    gcReset |-> gcLatch);

  a_r13_one_gc_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gcHwCall, gcLatch}));

endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer
  import i2c_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [ADDR_W-1:0]    ownAddr,
  input  logic                 tenBitMode,
  input  logic                 gcEnable,
  output logic                 sdaPullEn,
  output logic                 selected,
  output logic                 readMode,
  output logic                 gcLatch,
  output logic                 gcReset,
  output logic                 gcHwCall,
  output logic [HW_ADDR_W-1:0] gcMaster
);

  busEvt_t           evt;
  dpCtl_t            ctl;
  logic [BYTE_W-1:0] rxByte;

  i2c_bus_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .evt(evt), .rxByte(rxByte), .sdaPull(sdaPullEn)
  );

  i2c_addr_control u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode), .gcEnable(gcEnable),
    .ctl(ctl), .selected(selected), .readMode(readMode),
    .gcLatch(gcLatch), .gcReset(gcReset), .gcHwCall(gcHwCall),
    .gcMaster(gcMaster)
  );

  // R14: a reserved first byte is never followed by an acknowledge
  a_r14_reserved_never_acked: assert property (@(posedge clk) disable iff (!rstN)
    (evt.byteEnd && u_ctl.state == ST_ADDR1 &&
     (rxByte[7:3] == 5'b11111 || (rxByte[7:4] == 4'b0000 && rxByte != 8'h00)))
    |=> !sdaPullEn);

endmodule

// File: tb/i2c_addr_recognizer_test.sv
module i2c_addr_recognizer_test;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [9:0] ownAddr = 10'h05A;
  logic tenBitMode = 1'b0, gcEnable = 1'b0;
  logic sdaPullEn, selected, readMode, gcLatch, gcReset, gcHwCall;
  logic [6:0] gcMaster;
  logic sdaBus;

  int total = 0, bad = 0;
  int nLatch = 0, nReset = 0, nHw = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sdaBus = sdaDrv & ~sdaPullEn;

  i2c_addr_recognizer uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode), .gcEnable(gcEnable),
    .sdaPullEn(sdaPullEn), .selected(selected), .readMode(readMode),
    .gcLatch(gcLatch), .gcReset(gcReset), .gcHwCall(gcHwCall),
    .gcMaster(gcMaster)
  );

  always @(posedge clk) begin
    if (gcLatch) nLatch <= nLatch + 1;
    if (gcReset) nReset <= nReset + 1;
    if (gcHwCall) nHw <= nHw + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; pause(QTR);
    sclDrv = 1'b1; pause(QTR);
    sdaDrv = 1'b0; pause(QTR);
    sclDrv = 1'b0; pause(QTR);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; pause(QTR);
    sclDrv = 1'b1; pause(QTR);
    sdaDrv = 1'b1; pause(QTR);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; pause(QTR);
      sclDrv = 1'b1; pause(2 * QTR);
      sclDrv = 1'b0; pause(QTR);
    end
    sdaDrv = 1'b1; pause(QTR);
    sclDrv = 1'b1; pause(QTR);
    acked = ~sdaBus;
    pause(QTR);
    sclDrv = 1'b0; pause(QTR);
  endtask

  task automatic testReset();
    check("R1 pull", sdaPullEn, 0);
    check("R1 selected", selected, 0);
    check("R1 readMode", readMode, 0);
    check("R1 gc strobes", {gcLatch, gcReset, gcHwCall}, 0);
  endtask

  task automatic test7Write();
    logic a;
    tenBitMode = 0; ownAddr = 10'h05A;
    busStart(); sendByte(8'hB4, a);
    check("R2 addr ack", a, 1);
    check("R2 selected", selected, 1);
    check("R2 readMode", readMode, 0);
    sendByte(8'h33, a); check("R2 data ack", a, 1);
    busStop();
    check("R5 stop clears selected", selected, 0);
  endtask

  task automatic test7Mismatch();
    logic a;
    busStart(); sendByte(8'hB6, a);
    check("R3 no ack", a, 0);
    check("R3 not selected", selected, 0);
    sendByte(8'h00, a); check("R3 data ignored", a, 0);
    busStop();
  endtask

  task automatic test7Read();
    logic a;
    busStart(); sendByte(8'hB5, a);
    check("R4 ack", a, 1);
    check("R4 readMode", readMode, 1);
    check("R4 selected", selected, 1);
    busStop();
    check("R5 readMode cleared", readMode, 0);
  endtask

  task automatic testRestart();
    logic a;
    busStart(); sendByte(8'hB4, a);
    check("R6 first select", selected, 1);
    busStart(); sendByte(8'hB5, a);
    check("R6 same addr ack", a, 1);
    check("R6 direction read", readMode, 1);
    busStart(); sendByte(8'h40, a);
    check("R6 other addr no ack", a, 0);
    check("R6 deselected", selected, 0);
    busStop();
  endtask

  task automatic test10WriteRead();
    logic a;
    tenBitMode = 1; ownAddr = 10'h2C7;
    busStart(); sendByte(8'hF4, a);
    check("R7 first byte ack", a, 1);
    check("R7 not yet selected", selected, 0);
    sendByte(8'hC7, a);
    check("R7 second byte ack", a, 1);
    check("R7 selected", selected, 1);
    check("R7 write", readMode, 0);
    sendByte(8'h11, a); check("R7 data ack", a, 1);
    busStart(); sendByte(8'hF5, a);
    check("R9 read ack", a, 1);
    check("R9 selected", selected, 1);
    check("R9 readMode", readMode, 1);
    busStop();
  endtask

  task automatic test10Bad();
    logic a;
    busStart(); sendByte(8'hF4, a);
    check("R8 first byte ack", a, 1);
    sendByte(8'hC6, a);
    check("R8 second byte no ack", a, 0);
    check("R8 not selected", selected, 0);
    busStart(); sendByte(8'hF2, a);
    check("R8 wrong prefix bits", a, 0);
    busStop();
    busStart(); sendByte(8'hF5, a);
    check("R10 cold read no ack", a, 0);
    check("R10 not selected", selected, 0);
    busStop();
  endtask

  task automatic testGc();
    logic a;
    int l0, r0, h0;
    tenBitMode = 0; ownAddr = 10'h05A; gcEnable = 1;
    l0 = nLatch; r0 = nReset;
    busStart(); sendByte(8'h00, a); check("R11 gc ack", a, 1);
    check("R11 gc not selected", selected, 0);
    sendByte(8'h06, a); check("R12 0x06 ack", a, 1);
    pause(2);
    check("R12 0x06 latch", nLatch - l0, 1);
    check("R12 0x06 reset", nReset - r0, 1);
    busStop();
    l0 = nLatch; r0 = nReset;
    busStart(); sendByte(8'h00, a); sendByte(8'h04, a);
    check("R12 0x04 ack", a, 1);
    pause(2);
    check("R12 0x04 latch", nLatch - l0, 1);
    check("R12 0x04 no reset", nReset - r0, 0);
    busStop();
    l0 = nLatch; h0 = nHw;
    busStart(); sendByte(8'h00, a); sendByte(8'h00, a);
    check("R12 0x00 no ack", a, 0);
    busStart(); sendByte(8'h00, a); sendByte(8'h02, a);
    check("R12 0x02 no ack", a, 0);
    pause(2);
    check("R12 no strobes", (nLatch - l0) + (nHw - h0), 0);
    busStart(); sendByte(8'h00, a); sendByte(8'h35, a);
    check("R13 odd ack", a, 1);
    pause(2);
    check("R13 hw strobe", nHw - h0, 1);
    check("R13 master addr", gcMaster, 7'h1A);
    busStop();
    gcEnable = 0;
    busStart(); sendByte(8'h00, a);
    check("R11 gc disabled no ack", a, 0);
    busStop();
  endtask

  task automatic testReserved();
    logic a;
    tenBitMode = 0; ownAddr = 10'h05A; gcEnable = 1;
    busStart(); sendByte(8'h02, a); check("R14 0000001 no ack", a, 0);
    busStart(); sendByte(8'h01, a); check("R14 start byte no ack", a, 0);
    busStart(); sendByte(8'hF8, a); check("R14 11111xx no ack", a, 0);
    ownAddr = 10'h003;
    busStart(); sendByte(8'h06, a); check("R14 reserved own addr", a, 0);
    ownAddr = 10'h07C;
    busStart(); sendByte(8'hF8, a); check("R14 1111xxx own 7-bit", a, 0);
    tenBitMode = 1; ownAddr = 10'h3C7;
    busStart(); sendByte(8'hFE, a); check("R14 11111xx 10-bit mode", a, 0);
    busStop();
    gcEnable = 0;
  endtask

  initial begin
    pause(5);
    rstN = 1'b1;
    pause(5);
    testReset();
    test7Write();
    test7Mismatch();
    test7Read();
    testRestart();
    test10WriteRead();
    test10Bad();
    testGc();
    testReserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule